// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block sits between a simple host request port and an asynchronous dynamic memory whose row and column addresses share one set of pins. Each host request carries a flat word address, a write flag and write data. The controller splits the address into a row part and a column part. It presents the row and then lowers the row strobe. It presents the column and then lowers the column strobe, with the write-enable and output-enable lines set for the direction of the transfer. Read data comes back to the host with a single-cycle valid pulse.

After an access the row stays open. A later request to the same row needs only a new column strobe. A request to another row first raises the row strobe and waits out the precharge time before it opens the new row. A free-running timer asks for a refresh at a fixed interval. At the next idle point the controller closes any open page and activates the next row from a wrapping row counter with the column strobe held high. This row-only activation restores the charge in that row. The refresh goes ahead of any host request that is waiting.

Top module: `dram_async_ctrl`

## Requirements
- R1: During and right after reset the row strobe, column strobe, write enable and output enable (all active low) are high, the data bus driver is off, `rd_valid` is low and `req_ready` is high.
- R2: The row is the upper ROW_W bits of `req_addr` and the column is the lower COL_W bits. Each of them is on `dram_addr` in the cycle before its strobe falls and in the cycle it falls.
- R3: The row strobe has been low for at least T_RCD cycles when the column strobe falls. The column strobe stays low for exactly T_CAS cycles.
- R4: While the column strobe is low for a write, write enable is low, output enable is high, `dram_dq_oe` is high and `dram_dq_out` carries the write data. For a read, write enable is high, output enable is low and `dram_dq_oe` is low.
- R5: For a read, `rd_valid` is high for exactly one cycle: the cycle in which the column strobe rises. `rd_data` then holds the word that was on `dram_dq_in` during the last strobe-low cycle. Writes never raise `rd_valid`.
- R6: When the previous access used the same row and no refresh has happened since, the access issues a column strobe with no falling edge on the row strobe.
- R7: Before any falling edge of the row strobe, the row strobe has been high for at least T_RP+1 cycles. An access to a row other than the open one therefore closes the page, precharges and makes exactly one new row activation.
- R8: A refresh holds the row strobe low for exactly T_RCD+T_CAS cycles with the column strobe high throughout. Refreshes recur every REF_INTERVAL cycles, each within a small fixed slack, even when host traffic is continuous.
- R9: Refreshes visit the rows in order, starting at row 0, and wrap from the last row back to row 0.
- R10: `req_ready` is low while an access or refresh is in progress (including every cycle the column strobe is low and the cycle after a request is accepted). It is high only when the controller is idle and no refresh is pending.
- R11: An open page is closed before a refresh: the refresh row is activated only after the row strobe has risen and met the precharge time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_dq_out | output | DATA_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
A wrong open-row register or page-valid flag shows up at the next same-row request. Either a row-strobe edge appears where none should, or a column strobe falls with a stale row latched in the memory. Either is visible within one access. A wrong refresh counter shows up when the next refresh activates a row out of sequence. Refreshes come tens of cycles apart. Timing-counter faults change the strobe pulse widths of the very access they hit. A mis-latched direction or data register shows up as a wrong word on the following read-back.

// File: rtl/dramc_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM controller: controller states and the
// destination taken once a precharge completes.
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting; page may be open (row strobe low)
        ST_PRE,     // row strobe high, precharge count
        ST_ROW,     // row address setup, row strobe still high
        ST_RCD,     // row strobe low, row-to-column wait
        ST_COL,     // column address setup, column strobe high
        ST_STROBE,  // column strobe low, data transfer
        ST_RROW,    // refresh row address setup
        ST_RACT     // refresh activation, column strobe high
    } ctrl_state_e;

    typedef enum logic [1:0] {
        GO_ACCESS,
        GO_REFRESH,
        GO_IDLE
    } pre_goal_e;

endpackage

// File: rtl/dramc_refresh.sv
`timescale 1ns/1ps
// Refresh scheduler.
// Raises a pending flag every INTERVAL cycles and keeps the row to
// refresh next. Assumes the controller pulses `grant` once it starts
// servicing a pending refresh and `done` once that refresh's
// activation ends. The row counter moves on `done` and wraps.
module dramc_refresh #(
    parameter int ROW_W    = 4,
    parameter int INTERVAL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic             done,
    output logic             pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tick_cnt_q;
    logic          tick;

    assign tick = (tick_cnt_q == TW'(INTERVAL - 1));

    // Interval timer, free running.
    always_ff @(posedge clk) begin
        if (!rst_n)    tick_cnt_q <= '0;
        else if (tick) tick_cnt_q <= '0;
        else           tick_cnt_q <= tick_cnt_q + 1'b1;
    end

    // Pending flag: set by the timer, cleared by the grant.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (tick)  pending <= 1'b1;
        else if (grant) pending <= 1'b0;
    end

    // Row counter: advance after each refresh, wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    ref_row <= '0;
        else if (done) ref_row <= ref_row + 1'b1;
    end

endmodule

// File: rtl/dramc_addr_split.sv
`timescale 1ns/1ps
// Splits a flat word address into row and column fields and compares
// the row with the page held open. Purely combinational.
module dramc_addr_split #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4
) (
    input  logic [ROW_W+COL_W-1:0] flat_addr,
    input  logic [ROW_W-1:0]       open_row,
    input  logic                   page_open,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic                   page_hit
);
    // Field split: row in the upper bits, column in the lower bits.
    assign row = flat_addr[ROW_W+COL_W-1:COL_W];
    assign col = flat_addr[COL_W-1:0];

    // Hit only when a page is open and its row matches.
    assign page_hit = page_open && (row == open_row);

endmodule

// File: rtl/dram_async_ctrl.sv
`timescale 1ns/1ps
// Multiplexed-address DRAM controller with periodic row refresh.
// Turns host requests into row/column strobe sequences and leaves the
// row open after each access (page mode). Strobe and address outputs
// are decoded from registered state only. Assumes T_RCD, T_CAS and
// T_RP are at least 1, and REF_INTERVAL is well above one access time.
module dram_async_ctrl
    import dramc_pkg::*;
#(
    parameter int ROW_W        = 4,
    parameter int COL_W        = 4,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 2,
    parameter int REF_INTERVAL = 64,
    localparam int FLAT_W      = ROW_W + COL_W,
    localparam int AW          = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [FLAT_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [AW-1:0]     dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int T_RAS = T_RCD + T_CAS;
    localparam int CW    = $clog2(T_RAS + T_RP + 1);

    ctrl_state_e       state_q;
    pre_goal_e         goal_q;
    logic [CW-1:0]     cnt_q;
    logic              page_open_q;
    logic [ROW_W-1:0]  open_row_q;
    logic [ROW_W-1:0]  acc_row_q;
    logic [COL_W-1:0]  acc_col_q;
    logic              acc_wr_q;
    logic [DATA_W-1:0] acc_wd_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    logic             ref_pending;
    logic [ROW_W-1:0] ref_row;
    logic             ref_grant;
    logic             ref_done;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             req_hit;
    logic             accept;
    logic             in_col_phase;

    dramc_refresh #(
        .ROW_W   (ROW_W),
        .INTERVAL(REF_INTERVAL)
    ) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .grant  (ref_grant),
        .done   (ref_done),
        .pending(ref_pending),
        .ref_row(ref_row)
    );

    dramc_addr_split #(
        .ROW_W(ROW_W),
        .COL_W(COL_W)
    ) u_split (
        .flat_addr(req_addr),
        .open_row (open_row_q),
        .page_open(page_open_q),
        .row      (req_row),
        .col      (req_col),
        .page_hit (req_hit)
    );

    // Host handshake: ready only in idle with no refresh waiting.
    assign req_ready = (state_q == ST_IDLE) && !ref_pending;
    assign accept    = req_valid && req_ready;

    // Refresh handshake pulses towards the scheduler.
    assign ref_grant = (state_q == ST_RROW);
    assign ref_done  = (state_q == ST_RACT) && (cnt_q == CW'(T_RAS - 1));

    // Main sequencer: state, phase counter and page tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            goal_q      <= GO_IDLE;
            cnt_q       <= '0;
            page_open_q <= 1'b0;
            open_row_q  <= '0;
            acc_row_q   <= '0;
            acc_col_q   <= '0;
            acc_wr_q    <= 1'b0;
            acc_wd_q    <= '0;
            rd_data_q   <= '0;
            rd_valid_q  <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (ref_pending) begin
                        if (page_open_q) begin
                            state_q     <= ST_PRE;
                            goal_q      <= GO_REFRESH;
                            page_open_q <= 1'b0;
                        end else begin
                            state_q <= ST_RROW;
                        end
                    end else if (accept) begin
                        acc_row_q <= req_row;
                        acc_col_q <= req_col;
                        acc_wr_q  <= req_write;
                        acc_wd_q  <= req_wdata;
                        if (req_hit) begin
                            state_q <= ST_COL;
                        end else if (page_open_q) begin
                            state_q     <= ST_PRE;
                            goal_q      <= GO_ACCESS;
                            page_open_q <= 1'b0;
                        end else begin
                            state_q <= ST_ROW;
                        end
                    end
                end
                ST_PRE: begin
                    if (cnt_q == CW'(T_RP - 1)) begin
                        cnt_q <= '0;
                        case (goal_q)
                            GO_ACCESS:  state_q <= ST_ROW;
                            GO_REFRESH: state_q <= ST_RROW;
                            default:    state_q <= ST_IDLE;
                        endcase
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ROW: begin
                    state_q     <= ST_RCD;
                    cnt_q       <= '0;
                    page_open_q <= 1'b1;
                    open_row_q  <= acc_row_q;
                end
                ST_RCD: begin
                    if (cnt_q == CW'(T_RCD - 1)) begin
                        state_q <= ST_COL;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_COL: begin
                    state_q <= ST_STROBE;
                    cnt_q   <= '0;
                end
                ST_STROBE: begin
                    if (cnt_q == CW'(T_CAS - 1)) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                        if (!acc_wr_q) begin
                            rd_data_q  <= dram_dq_in;
                            rd_valid_q <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RROW: begin
                    state_q <= ST_RACT;
                    cnt_q   <= '0;
                end
                ST_RACT: begin
                    if (cnt_q == CW'(T_RAS - 1)) begin
                        state_q <= ST_PRE;
                        goal_q  <= GO_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_col_phase = (state_q == ST_COL) || (state_q == ST_STROBE);

    // Strobe decode from registered state.
    always_comb begin
        dram_ras_n = !((state_q == ST_RCD) || in_col_phase ||
                       (state_q == ST_RACT) ||
                       ((state_q == ST_IDLE) && page_open_q));
        dram_cas_n = !(state_q == ST_STROBE);
        dram_we_n  = !(in_col_phase && acc_wr_q);
        dram_oe_n  = !(in_col_phase && !acc_wr_q);
        dram_dq_oe = in_col_phase && acc_wr_q;
    end

    // Shared address pin multiplexer.
    always_comb begin
        case (state_q)
            ST_ROW, ST_RCD:     dram_addr = AW'(acc_row_q);
            ST_COL, ST_STROBE:  dram_addr = AW'(acc_col_q);
            ST_RROW, ST_RACT:   dram_addr = AW'(ref_row);
            default:            dram_addr = '0;
        endcase
    end

    assign dram_dq_out = acc_wd_q;
    assign rd_data     = rd_data_q;
    assign rd_valid    = rd_valid_q;

endmodule

// File: rtl/dramc_checker.sv
`timescale 1ns/1ps
// Protocol checker for dram_async_ctrl, attached by bind. Watches only
// the top-level pins and keeps its own pulse-width counters.
module dramc_checker #(
    parameter int T_CAS = 2,
    parameter int T_RP  = 2,
    parameter int AW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          dq_oe,
    input logic [AW-1:0] addr,
    input logic          ready,
    input logic          rdv
);
    localparam int RP_MIN = T_RP + 1;

    logic [7:0] cas_lo_cnt;
    logic [7:0] ras_hi_cnt;

    // Counts cycles the column strobe has been low.
    always_ff @(posedge clk) begin
        if (!rst_n)      cas_lo_cnt <= '0;
        else if (!cas_n) cas_lo_cnt <= (cas_lo_cnt == 8'hFF) ? cas_lo_cnt : cas_lo_cnt + 1'b1;
        else             cas_lo_cnt <= '0;
    end

    // Counts cycles the row strobe has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ras_hi_cnt <= 8'(RP_MIN);
        else if (!ras_n)            ras_hi_cnt <= '0;
        else if (ras_hi_cnt < 8'(RP_MIN)) ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end

    p_ras_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(addr));

    p_cas_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(addr));

    p_cas_in_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    p_cas_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (cas_lo_cnt == 8'(T_CAS)));

    p_dir_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    p_drive_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && oe_n));

    p_rdv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdv |=> !rdv);

    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_cnt >= 8'(RP_MIN)));

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ready);

endmodule

bind dram_async_ctrl dramc_checker #(
    .T_CAS(T_CAS),
    .T_RP (T_RP),
    .AW   (AW)
) u_dramc_checker (
    .clk  (clk),
    .rst_n(rst_n),
    .ras_n(dram_ras_n),
    .cas_n(dram_cas_n),
    .we_n (dram_we_n),
    .oe_n (dram_oe_n),
    .dq_oe(dram_dq_oe),
    .addr (dram_addr),
    .ready(req_ready),
    .rdv  (rd_valid)
);

// File: tb/dram_async_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: behavioural memory device plus a per-cycle pin monitor that
// checks strobe timing, address phases, refresh order and read data
// against a host-side shadow memory.
module dram_async_ctrl_bench;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 4;
    localparam int DATA_W = 8;
    localparam int T_RCD  = 2;
    localparam int T_CAS  = 2;
    localparam int T_RP   = 2;
    localparam int REF_IV = 64;
    localparam int FLAT_W = ROW_W + COL_W;
    localparam int AW     = 4;
    localparam int WORDS  = 1 << FLAT_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int SLACK  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [FLAT_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [AW-1:0]     dram_addr;
    logic [DATA_W-1:0] dram_dq_out;
    logic [DATA_W-1:0] dram_dq_in;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] dev_mem [WORDS];
    logic [DATA_W-1:0] exp_mem [WORDS];
    logic [ROW_W-1:0]  dev_row = '0;

    logic [DATA_W-1:0]          rdq[$];
    logic [1+FLAT_W+DATA_W-1:0] accq[$];

    always #2.5 clk = ~clk;

    dram_async_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_IV)
    ) u_dram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    // Memory device read path: drives data while both strobes allow it.
    assign dram_dq_in = (!dram_oe_n && !dram_cas_n) ?
                        dev_mem[{dev_row, dram_addr[COL_W-1:0]}] : '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle monitor state.
    logic p_ras = 1'b1, p_cas = 1'b1, p_rdv = 1'b0;
    logic [AW-1:0] p_addr = '0;
    int ras_lo = 0, ras_hi = 100, cas_lo = 0;
    int acc_falls = 0, nref = 0, gap = 0, cyc = 0;
    bit have_prev = 0, ref_since = 0, cas_in_period = 0, cur_wr = 0;
    logic [ROW_W-1:0] prev_row = '0;
    logic [ROW_W-1:0] exp_ref_row = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            gap++;
            if (cyc > 150000) begin
                chk(0, "R10", "watchdog cycles", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
            if (!dram_cas_n)
                chk(req_ready == 1'b0, "R10", "ready while strobing", int'(req_ready), 0);
            // Row strobe falls: setup, precharge, latch row.
            if (p_ras && !dram_ras_n) begin
                chk(dram_addr == p_addr, "R2", "row addr setup", int'(dram_addr), int'(p_addr));
                chk(ras_hi >= T_RP + 1, "R7", "precharge cycles", ras_hi, T_RP + 1);
                dev_row = dram_addr[ROW_W-1:0];
                acc_falls++;
                cas_in_period = 0;
            end
            // Column strobe falls: check the access against the queue.
            if (p_cas && !dram_cas_n) begin
                logic [1+FLAT_W+DATA_W-1:0] e;
                logic e_wr;
                logic [ROW_W-1:0] e_row;
                logic [COL_W-1:0] e_col;
                logic [DATA_W-1:0] e_d;
                int exp_falls;
                chk(ras_lo >= T_RCD, "R3", "row-to-column cycles", ras_lo, T_RCD);
                chk(dram_addr == p_addr, "R2", "col addr setup", int'(dram_addr), int'(p_addr));
                if (accq.size() == 0) begin
                    chk(0, "R2", "unexpected column strobe", 1, 0);
                end else begin
                    e = accq.pop_front();
                    {e_wr, e_row, e_col, e_d} = e;
                    chk(dev_row == e_row, "R2", "row field", int'(dev_row), int'(e_row));
                    chk(dram_addr[COL_W-1:0] == e_col, "R2", "col field",
                        int'(dram_addr[COL_W-1:0]), int'(e_col));
                    if (e_wr) begin
                        chk(!dram_we_n && dram_oe_n && dram_dq_oe, "R4", "write pins",
                            int'({dram_we_n, dram_oe_n, dram_dq_oe}), 3'b011);
                        chk(dram_dq_out == e_d, "R4", "write data", int'(dram_dq_out), int'(e_d));
                        dev_mem[{dev_row, dram_addr[COL_W-1:0]}] = dram_dq_out;
                    end else begin
                        chk(dram_we_n && !dram_oe_n && !dram_dq_oe, "R4", "read pins",
                            int'({dram_we_n, dram_oe_n, dram_dq_oe}), 3'b100);
                    end
                    exp_falls = (have_prev && e_row == prev_row && !ref_since) ? 0 : 1;
                    if (exp_falls == 0)
                        chk(acc_falls == 0, "R6", "row strobes on page hit", acc_falls, 0);
                    else
                        chk(acc_falls == 1, "R7", "row strobes on page miss", acc_falls, 1);
                    prev_row = e_row;
                    cur_wr = e_wr;
                end
                have_prev = 1;
                ref_since = 0;
                acc_falls = 0;
                cas_in_period = 1;
            end
            // Column strobe rises: width and read pulse timing.
            if (!p_cas && dram_cas_n) begin
                chk(cas_lo == T_CAS, "R3", "column strobe width", cas_lo, T_CAS);
                chk(rd_valid == !cur_wr, "R5", "read pulse at strobe end", int'(rd_valid), int'(!cur_wr));
            end else if (rd_valid) begin
                chk(0, "R5", "stray read pulse", 1, 0);
            end
            if (rd_valid) begin
                chk(!p_rdv, "R5", "pulse length", 2, 1);
                if (rdq.size() == 0) chk(0, "R5", "read without request", 1, 0);
                else begin
                    logic [DATA_W-1:0] x;
                    x = rdq.pop_front();
                    chk(rd_data == x, "R5", "read data", int'(rd_data), int'(x));
                end
            end
            // Row strobe rises with no column strobe: a refresh.
            if (!p_ras && dram_ras_n && !cas_in_period) begin
                chk(dev_row == exp_ref_row, "R9", "refresh row", int'(dev_row), int'(exp_ref_row));
                chk(ras_lo == T_RCD + T_CAS, "R8", "refresh activation", ras_lo, T_RCD + T_CAS);
                if (nref > 0) begin
                    chk(gap <= REF_IV + SLACK, "R8", "refresh gap max", gap, REF_IV + SLACK);
                    chk(gap >= REF_IV - SLACK, "R8", "refresh gap min", gap, REF_IV - SLACK);
                end
                nref++;
                exp_ref_row = ROW_W'((int'(exp_ref_row) + 1) % ROWS);
                acc_falls--;
                ref_since = 1;
                gap = 0;
            end
            if (!dram_cas_n && dram_ras_n) chk(0, "R11", "column strobe with row closed", 1, 0);
            if (dram_ras_n) begin ras_hi++; ras_lo = 0; end
            else begin ras_lo++; ras_hi = 0; end
            if (dram_cas_n) cas_lo = 0; else cas_lo++;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_addr = dram_addr;
            p_rdv = rd_valid;
        end
    end

    // Issue one host request from a falling edge; returns on a falling edge.
    task automatic host_req(input logic wr, input logic [FLAT_W-1:0] a, input logic [DATA_W-1:0] d);
        bit got;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        got = 0;
        while (!got) begin
            got = req_ready;
            @(negedge clk);
        end
        if (wr) exp_mem[a] = d;
        else    rdq.push_back(exp_mem[a]);
        accq.push_back({wr, a, d});
        chk(req_ready == 1'b0, "R10", "ready after accept", int'(req_ready), 0);
        req_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            dev_mem[i] = '0;
            exp_mem[i] = '0;
        end
        repeat (4) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes in reset",
            int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 4'hF);
        chk(!dram_dq_oe && !rd_valid, "R1", "driver and valid in reset",
            int'({dram_dq_oe, rd_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(dram_ras_n == 1'b1, "R1", "row strobe after reset", int'(dram_ras_n), 1);
        // Fill every word: consecutive same-row writes exercise page hits (R6).
        for (int a = 0; a < WORDS; a++)
            host_req(1'b1, FLAT_W'(a), DATA_W'((a * 7 + 3) ^ 8'h5A));
        // Idle with the page open so a refresh must close it (R11).
        repeat (150) @(negedge clk);
        // Scrambled read-back: mostly row misses (R7, R5).
        for (int i = 0; i < WORDS; i++)
            host_req(1'b0, FLAT_W'((i * 97 + 13) % WORDS), '0);
        // Mixed traffic in short same-row bursts.
        for (int i = 0; i < 120; i++) begin
            int r, c;
            r = ((i / 4) * 53) % ROWS;
            c = (i * 5) % (1 << COL_W);
            host_req((i % 3) == 0, FLAT_W'(r * (1 << COL_W) + c), DATA_W'(i * 11));
        end
        for (int k = 0; k < 200 && (rdq.size() != 0 || accq.size() != 0); k++)
            @(negedge clk);
        chk(rdq.size() == 0 && accq.size() == 0, "R5", "outstanding requests",
            rdq.size() + accq.size(), 0);
        chk(nref > ROWS, "R9", "refreshes wrapped", nref, ROWS + 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule